// File: doc/BRIEF.md
# Nanosecond Time Counter

This block keeps a free-running time-of-day count, in nanoseconds, for precision time protocol hardware. On every reference clock edge, while it is running, the count moves forward by a programmable step. A correction scheduler picks every P-th running cycle and uses a second, alternate step on that cycle instead of the base step. Choosing P and the alternate step trims the average rate in fine fractions of a nanosecond per cycle.

The count can wrap at a programmable period, and a one-cycle pulse marks each wrap so that compare logic can follow it. Software drives the block through a plain single-cycle register port. Every write takes effect at the clock edge it is presented on, and reads are combinational from the current address. The port has no valid/ready handshake because no write can be refused or delayed. Software can freeze the live count into a snapshot register to read it, load a new count directly, or restart the count from zero.

Top module: `ns_timebase`

## Requirements
- R1: After reset, time_ns is 0, wrap_pulse and follower_mode are 0, and every register reads 0.
- R2: While control bit 0 (run) is 0, time_ns holds its value and the correction phase does not advance.
- R3: With run set and a correction period of 0, time_ns grows on every clock by the base step held in bits [6:0] of the step register (address 2).
- R4: With a correction period P > 0 (address 3), every P-th running cycle after a restart adds the correction step in bits [14:8] of the step register instead of the base step. All other running cycles add the base step.
- R5: When control bits 5 and 4 are both 1 and count plus step reaches or exceeds the wrap period (address 4), the count becomes count plus step minus period, and wrap_pulse is 1 for that one cycle. With a wrap period of 0x80000000 this gives a 31-bit counter. If either bit is 0, the count rolls over at 2^32 and wrap_pulse stays 0.
- R6: A control write with bit 11 (capture) set copies the count from before that edge into the snapshot, which reads back at address 1. Bit 11 reads 1 for the one cycle after the write and then clears itself.
- R7: A write to address 1 loads time_ns with the written value on that edge, and counting continues from it.
- R8: A control write with bit 9 set makes time_ns 0 on that edge and resets the correction phase. Bit 9 is not stored and reads 0.
- R9: Control bit 13 is stored and drives follower_mode.
- R10: The register map is 0 control, 1 count snapshot/load, 2 step, 3 correction period, 4 wrap period. Unimplemented bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| time_ns | output | 32 | Live nanosecond count |
| wrap_pulse | output | 1 | One-cycle pulse on each period wrap |
| follower_mode | output | 1 | Stored follower (slave) mode select |

## Verification
The rate path is driven with five step/correction combinations:
- no correction;
- correction on every cycle;
- sparse correction with a larger alternate step;
- sparse correction with a smaller alternate step;
- a zero alternate step.

Comparing the end count after a known number of cycles tells apart an error in the base step, an error in the correction step, and an off-by-one in the correction phase. Wrapping is exercised with a small period that is overshot rather than hit exactly, with a half-enabled wrap select, and with the 31-bit period. These separate subtract-the-period wrapping from clear-to-zero wrapping and from natural rollover.

// File: rtl/ns_timebase_pkg.sv
package ns_timebase_pkg;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_COUNT = 3'd1;
  localparam logic [REG_AW-1:0] ADR_STEP  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_CPER  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_WRAP  = 3'd4;

  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_WRAP_A  = 4;
  localparam int unsigned CB_WRAP_B  = 5;
  localparam int unsigned CB_RESTART = 9;
  localparam int unsigned CB_CAPTURE = 11;
  localparam int unsigned CB_FOLLOW  = 13;

  localparam int unsigned CORR_LSB = 8;

  typedef struct packed {
    logic       follow;
    logic       capture;
    logic [1:0] wrap_sel;
    logic       run;
  } ctrl_t;

endpackage

// File: rtl/ns_timebase_regs.sv
module ns_timebase_regs
  import ns_timebase_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned STEP_W = 7,
  parameter int unsigned CPER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output ctrl_t             ctrl_o,
  output logic [STEP_W-1:0] base_step,
  output logic [STEP_W-1:0] corr_step,
  output logic [CPER_W-1:0] corr_period,
  output logic [CNT_W-1:0]  wrap_period,
  output logic              restart_req,
  output logic              load_req,
  output logic [CNT_W-1:0]  load_val
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  snap_q;
  logic [STEP_W-1:0] base_q, corr_q;
  logic [CPER_W-1:0] cper_q;
  logic [CNT_W-1:0]  wrap_q;

  logic ctrl_wr, cnt_wr, step_wr, cper_wr, wrap_wr, cap_wr;
  logic wdata_unused;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL);
  assign cnt_wr  = wr_en && (addr == ADR_COUNT);
  assign step_wr = wr_en && (addr == ADR_STEP);
  assign cper_wr = wr_en && (addr == ADR_CPER);
  assign wrap_wr = wr_en && (addr == ADR_WRAP);
  assign cap_wr  = ctrl_wr && wdata[CB_CAPTURE];
  assign wdata_unused = ^wdata;

  // control: capture bit self-clears one cycle after it is written
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.run      <= wdata[CB_RUN];
      ctrl_q.wrap_sel <= {wdata[CB_WRAP_B], wdata[CB_WRAP_A]};
      ctrl_q.capture  <= wdata[CB_CAPTURE];
      ctrl_q.follow   <= wdata[CB_FOLLOW];
    end else begin
      ctrl_q.capture  <= 1'b0;
    end
  end

  // snapshot takes the count present before the capture edge
  always_ff @(posedge clk) begin
    if (!rst_n)      snap_q <= '0;
    else if (cap_wr) snap_q <= live_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      corr_q <= '0;
      cper_q <= '0;
      wrap_q <= '0;
    end else begin
      if (step_wr) begin
        base_q <= wdata[STEP_W-1:0];
        corr_q <= wdata[CORR_LSB +: STEP_W];
      end
      if (cper_wr) cper_q <= wdata[CPER_W-1:0];
      if (wrap_wr) wrap_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[CB_RUN]     = ctrl_q.run;
        rdata[CB_WRAP_A]  = ctrl_q.wrap_sel[0];
        rdata[CB_WRAP_B]  = ctrl_q.wrap_sel[1];
        rdata[CB_CAPTURE] = ctrl_q.capture;
        rdata[CB_FOLLOW]  = ctrl_q.follow;
      end
      ADR_COUNT: rdata[CNT_W-1:0] = snap_q;
      ADR_STEP: begin
        rdata[STEP_W-1:0]         = base_q;
        rdata[CORR_LSB +: STEP_W] = corr_q;
      end
      ADR_CPER: rdata[CPER_W-1:0] = cper_q;
      ADR_WRAP: rdata[CNT_W-1:0]  = wrap_q;
      default:  rdata = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign base_step   = base_q;
  assign corr_step   = corr_q;
  assign corr_period = cper_q;
  assign wrap_period = wrap_q;
  assign restart_req = ctrl_wr && wdata[CB_RESTART];
  assign load_req    = cnt_wr;
  assign load_val    = wdata[CNT_W-1:0];

  // R6
  cap_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.capture && !cap_wr) |=> !ctrl_q.capture);

  // R6
  snap_takes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wr |=> (snap_q == $past(live_cnt)));

endmodule

// File: rtl/ns_timebase_corr.sv
module ns_timebase_corr #(
  parameter int unsigned CPER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [CPER_W-1:0] period,
  output logic              hit
);

  logic [CPER_W-1:0] phase_q;
  logic              active;

  assign active = |period;
  // the >= guards against a period lowered below the current phase
  assign hit = tick && active && (phase_q >= (period - CPER_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick) begin
      if (hit) phase_q <= '0;
      else     phase_q <= phase_q + CPER_W'(1);
    end
  end

  // R4
  phase_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (phase_q == '0));

  // R2
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/ns_timebase_accum.sv
module ns_timebase_accum #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap_en,
  input  logic [STEP_W-1:0] base_step,
  input  logic [STEP_W-1:0] corr_step,
  input  logic              corr_hit,
  input  logic [CNT_W-1:0]  period,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              restart,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap_pulse
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic              pulse_q;
  logic [STEP_W-1:0] step_sel;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  over;
  logic              wrap_now;

  assign step_sel = corr_hit ? corr_step : base_step;
  assign sum      = {1'b0, cnt_q} + SUM_W'(step_sel);
  assign over     = sum - {1'b0, period};
  assign wrap_now = wrap_en && (sum >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (restart) begin
        cnt_q <= '0;
      end else if (run) begin
        if (wrap_now) begin
          cnt_q   <= over[CNT_W-1:0];
          pulse_q <= 1'b1;
        end else begin
          cnt_q   <= sum[CNT_W-1:0];
        end
      end
    end
  end

  assign cnt        = cnt_q;
  assign wrap_pulse = pulse_q;

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load && !restart) |=> $stable(cnt_q));

  // R7
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !load) |=> (cnt_q == '0));

  // R5
  wrap_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en || !run || load || restart) |=> !pulse_q);

endmodule

// File: rtl/ns_timebase.sv
module ns_timebase
  import ns_timebase_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned STEP_W = 7,
  parameter int unsigned CPER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  time_ns,
  output logic              wrap_pulse,
  output logic              follower_mode
);

  ctrl_t             ctrl;
  logic [STEP_W-1:0] base_step, corr_step;
  logic [CPER_W-1:0] corr_period;
  logic [CNT_W-1:0]  wrap_period;
  logic              restart_req, load_req, corr_hit;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  live_cnt;

  ns_timebase_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_W(STEP_W), .CPER_W(CPER_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .live_cnt    (live_cnt),
    .ctrl_o      (ctrl),
    .base_step   (base_step),
    .corr_step   (corr_step),
    .corr_period (corr_period),
    .wrap_period (wrap_period),
    .restart_req (restart_req),
    .load_req    (load_req),
    .load_val    (load_val)
  );

  ns_timebase_corr #(.CPER_W(CPER_W)) u_corr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ctrl.run),
    .restart (restart_req),
    .period  (corr_period),
    .hit     (corr_hit)
  );

  ns_timebase_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.run),
    .wrap_en    (&ctrl.wrap_sel),
    .base_step  (base_step),
    .corr_step  (corr_step),
    .corr_hit   (corr_hit),
    .period     (wrap_period),
    .load       (load_req),
    .load_val   (load_val),
    .restart    (restart_req),
    .cnt        (live_cnt),
    .wrap_pulse (wrap_pulse)
  );

  assign time_ns       = live_cnt;
  assign follower_mode = ctrl.follow;

endmodule

// File: tb/ns_timebase_test.sv
module ns_timebase_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] time_ns;
  logic        wrap_pulse;
  logic        follower_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ns_timebase uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns),
    .wrap_pulse(wrap_pulse), .follower_mode(follower_mode)
  );

  typedef struct packed {
    logic [7:0]  base;
    logic [7:0]  corr;
    logic [7:0]  cper;
    logic [7:0]  ncyc;
    logic [31:0] expect_ns;
  } vec_t;

  // base, correction step, correction period, cycles, expected count
  localparam vec_t VECS [5] = '{
    '{8'd8,   8'd9,  8'd0, 8'd10, 32'd80},
    '{8'd8,   8'd9,  8'd4, 8'd10, 32'd82},
    '{8'd40,  8'd39, 8'd3, 8'd9,  32'd357},
    '{8'd1,   8'd3,  8'd1, 8'd5,  32'd15},
    '{8'd127, 8'd0,  8'd2, 8'd6,  32'd381}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 empty map
    chk("R1 time_ns", time_ns, 32'd0);
    chk("R1 wrap_pulse", {31'd0, wrap_pulse}, 32'd0);
    chk("R1 follower_mode", {31'd0, follower_mode}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register read", d, 32'd0);
    end
    @(negedge clk);

    // R10 step field masking
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d);
    chk("R10 step readback", d, 32'h0000_7F7F);
    @(negedge clk);

    // R3 / R4 table of rate vectors
    for (int i = 0; i < 5; i++) begin
      wr(3'd2, {16'd0, VECS[i].corr, VECS[i].base});
      wr(3'd3, {24'd0, VECS[i].cper});
      wr(3'd0, 32'h0000_0201);
      chk("R8 restart to zero", time_ns, 32'd0);
      repeat (int'(VECS[i].ncyc)) @(negedge clk);
      chk(VECS[i].cper == 8'd0 ? "R3 base rate" : "R4 corrected rate",
          time_ns, VECS[i].expect_ns);
    end

    // R2 stop holds the count
    wr(3'd0, 32'h0);
    held = time_ns;
    repeat (3) @(negedge clk);
    chk("R2 hold while stopped", time_ns, held);

    // R7 load
    wr(3'd2, 32'h0000_0008);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'd1000);
    chk("R7 load value", time_ns, 32'd1000);
    @(negedge clk);
    chk("R7 resume after load", time_ns, 32'd1008);

    // R8 restart, bit not stored
    wr(3'd0, 32'h0000_0201);
    chk("R8 restart", time_ns, 32'd0);
    rd(3'd0, d);
    chk("R8 restart bit reads 0", d, 32'h0000_0001);
    @(negedge clk);

    // R6 capture
    @(negedge clk);
    chk("R6 count before capture", time_ns, 32'd16);
    wr(3'd0, 32'h0000_0801);
    rd(3'd0, d);
    chk("R6 capture bit set", d, 32'h0000_0801);
    @(negedge clk);
    rd(3'd0, d);
    chk("R6 capture bit cleared", d, 32'h0000_0001);
    rd(3'd1, d);
    chk("R6 snapshot", d, 32'd16);
    chk("R6 live count kept running", time_ns, 32'd32);

    // R5 wrap with overshoot
    wr(3'd2, 32'd10);
    wr(3'd4, 32'd25);
    wr(3'd0, 32'h0000_0231);
    chk("R5 start", time_ns, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 before wrap", time_ns, 32'd20);
    @(negedge clk);
    chk("R5 wrapped count", time_ns, 32'd5);
    chk("R5 wrap pulse high", {31'd0, wrap_pulse}, 32'd1);
    @(negedge clk);
    chk("R5 after wrap", time_ns, 32'd15);
    chk("R5 wrap pulse one cycle", {31'd0, wrap_pulse}, 32'd0);

    // R5 half-enabled wrap: natural rollover
    wr(3'd0, 32'h0000_0011);
    wr(3'd1, 32'hFFFF_FFF8);
    @(negedge clk);
    chk("R5 rollover count", time_ns, 32'd2);
    chk("R5 rollover no pulse", {31'd0, wrap_pulse}, 32'd0);

    // R5 31-bit period
    wr(3'd4, 32'h8000_0000);
    wr(3'd0, 32'h0000_0031);
    wr(3'd1, 32'h7FFF_FFFC);
    @(negedge clk);
    chk("R5 31-bit wrap count", time_ns, 32'd6);
    chk("R5 31-bit wrap pulse", {31'd0, wrap_pulse}, 32'd1);

    // R9 follower mode
    wr(3'd0, 32'h0000_2000);
    chk("R9 follower_mode", {31'd0, follower_mode}, 32'd1);
    rd(3'd0, d);
    chk("R9 control readback", d, 32'h0000_2000);
    rd(3'd5, d);
    chk("R10 unused address", d, 32'd0);

    done = 1'b1;
    report();
  end

endmodule